// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns one SDRAM read or write command into its beat stream. When a start is requested, it captures the starting column, the burst length code and the ordering mode. On each following clock it presents the column of the current beat, the beat number, and a flag on the final beat. Lengths of 1, 2, 4 and 8 beats wrap inside a column block aligned to the burst length. The page mode walks the whole 512-column row and keeps going until it is told to stop.

For reads, the block delays each beat by the CAS latency (2 or 3 clocks) to form a data-valid strobe. It also applies the per-lane mask two clocks after the mask is sampled. For writes, the mask applies in the same clock, so the per-lane write enables are combinational. A stop input cuts the burst short, and the beat in the stopping clock is dropped. Command sequencing and refresh are handled elsewhere.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held, and after it is released, `beatValid`, `lastBeat`, `rdValid`, `rdLaneOe` and `wrLaneEn` are all low.
- R2: A start sampled at edge t gives `beatValid` high from edge t for L cycles. `beatIdx` runs 0..L-1, `lastBeat` is high only in the final beat, and `beatValid` falls after it. The `lenCode` values are 0=1, 1=2, 2=4 and 3=8 beats.
- R3: With `interleave`=0, beat k has column `(start & ~(L-1)) | ((start + k) mod L)`.
- R4: With `interleave`=1 and a length of 2 to 8, beat k has column `(start & ~(L-1)) | ((start mod L) XOR k)`.
- R5: `lenCode`=7 selects page mode. The order is sequential whatever `interleave` says, the column wraps from 511 to 0, `beatIdx` counts modulo 512, `lastBeat` never rises, and beats continue until a stop.
- R6: `burstStop` sampled high during a beat ends the burst, so `beatValid` is low in the next cycle. That beat gives no write enable and no read data.
- R7: For every read beat that is not cancelled, `rdValid` is high exactly CL cycles later, and at no other time. CL is 3 when `casIs3`=1 and 2 otherwise.
- R8: During a write beat, `wrLaneEn[i]` equals NOT `dqmIn[i]` in the same cycle (write mask latency 0). At all other times it is 0.
- R9: `rdLaneOe[i]` equals `rdValid` AND NOT the `dqmIn[i]` value held two cycles earlier (read mask latency 2).
- R10: The `lenCode` values 4, 5 and 6 behave as a one-beat burst.
- R11: A start during a burst abandons the old burst. The new burst begins at the next edge with `beatIdx`=0, and the beat in the start cycle still completes. If `startRd` and `startWr` are both high, the read wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| startRd | input | 1 | Begin a read burst |
| startWr | input | 1 | Begin a write burst |
| startCol | input | COL_W | First column of the burst |
| lenCode | input | 3 | Burst length code |
| interleave | input | 1 | 1 selects interleaved ordering |
| casIs3 | input | 1 | CAS latency select: 1 = 3 clocks, 0 = 2 clocks |
| burstStop | input | 1 | Terminate the running burst |
| dqmIn | input | MASK_W | Per-lane data mask |
| beatValid | output | 1 | A beat is being presented |
| beatIdx | output | COL_W | Beat number within the burst |
| beatCol | output | COL_W | Column address of the beat |
| lastBeat | output | 1 | Final beat of a fixed-length burst |
| rdValid | output | 1 | Read data valid after CAS latency |
| rdLaneOe | output | MASK_W | Per-lane read output enable |
| wrLaneEn | output | MASK_W | Per-lane write enable |

## Verification
The bench sweeps every length code, both orderings and every start offset inside a 16-column window. It does this for reads and writes, with the CAS latency alternating between bursts. A wrong wrap would show up as a column that leaves its aligned block, and a swapped ordering as a column sequence that matches the other mode. Separate runs check a page burst that crosses column 511, stops that cut both reads and writes short, and a restart in mid-burst. A stop that failed to cancel its beat would leak one write enable or one extra read strobe. The mask is varied on every beat, so a read mask applied one clock early or late makes a lane enable disagree with the model.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  // strobes from the control unit to the datapath
  typedef struct packed {
    logic load;      // capture start column, clear beat counter
    logic advance;   // step the beat counter
    logic rdFire;    // a read beat completes this cycle
    logic wrFire;    // a write beat completes this cycle
  } seqStrobe_t;

  localparam logic [2:0] LEN_PAGE   = 3'd7;
  localparam int         CAS_LO     = 2;
  localparam int         CAS_HI     = 3;
  localparam int         RD_DQM_LAT = 2;
endpackage

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startRd,
  input  logic             startWr,
  input  logic [2:0]       lenCode,
  input  logic             interleave,
  input  logic             burstStop,
  input  logic [COL_W-1:0] beatIdx,
  output seqStrobe_t       strb,
  output logic [COL_W-1:0] lenMaskQ,
  output logic             ilQ,
  output logic             beatValid,
  output logic             lastBeat
);
  logic             start;
  logic             active;
  logic             isRdQ;
  logic             fullPgQ;
  logic [COL_W-1:0] lenMaskNext;

  assign start = startRd | startWr;

  always_comb begin
    case (lenCode)
      3'd0:     lenMaskNext = '0;
      3'd1:     lenMaskNext = COL_W'(1);
      3'd2:     lenMaskNext = COL_W'(3);
      3'd3:     lenMaskNext = COL_W'(7);
      LEN_PAGE: lenMaskNext = '1;
      default:  lenMaskNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      isRdQ    <= 1'b0;
      fullPgQ  <= 1'b0;
      ilQ      <= 1'b0;
      lenMaskQ <= '0;
    end else if (start) begin
      active   <= 1'b1;
      isRdQ    <= startRd;
      fullPgQ  <= (lenCode == LEN_PAGE);
      ilQ      <= interleave & (lenCode != LEN_PAGE);
      lenMaskQ <= lenMaskNext;
    end else if (active && (burstStop || lastBeat)) begin
      active <= 1'b0;
    end
  end

  assign lastBeat     = active & ~fullPgQ & (beatIdx == lenMaskQ);
  assign beatValid    = active;
  assign strb.load    = start;
  assign strb.advance = active & ~burstStop & ~lastBeat;
  assign strb.rdFire  = active & isRdQ & ~burstStop;
  assign strb.wrFire  = active & ~isRdQ & ~burstStop;

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !start) |=> !beatValid);                              // R2
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && burstStop && !start) |=> !beatValid);                // R6
  AST_START_IDX0: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (beatValid && beatIdx == '0));                           // R11
endmodule

// File: rtl/bcs_dpath.sv
module bcs_dpath
  import bcs_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int MASK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [COL_W-1:0]  startCol,
  input  logic [COL_W-1:0]  lenMask,
  input  logic              il,
  input  logic              casIs3,
  input  logic [MASK_W-1:0] dqmIn,
  output logic [COL_W-1:0]  beatIdx,
  output logic [COL_W-1:0]  beatCol,
  output logic              rdValid,
  output logic [MASK_W-1:0] rdLaneOe,
  output logic [MASK_W-1:0] wrLaneEn
);
  logic [COL_W-1:0]  idxQ;
  logic [COL_W-1:0]  startColQ;
  logic [COL_W-1:0]  offset;
  logic              rdPipe [1:CAS_HI];
  logic [MASK_W-1:0] dqmPipe [1:RD_DQM_LAT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ      <= '0;
      startColQ <= '0;
    end else if (strb.load) begin
      idxQ      <= '0;
      startColQ <= startCol;
    end else if (strb.advance) begin
      idxQ <= idxQ + COL_W'(1);
    end
  end

  assign offset  = il ? (startColQ ^ idxQ) : (startColQ + idxQ);
  assign beatCol = (startColQ & ~lenMask) | (offset & lenMask);
  assign beatIdx = idxQ;

  for (genvar g = 1; g <= CAS_HI; g++) begin : gRdPipe
    always_ff @(posedge clk) begin
      if (!rstN) rdPipe[g] <= 1'b0;
      else if (g == 1) rdPipe[g] <= strb.rdFire;
      else rdPipe[g] <= rdPipe[g-1];
    end
  end

  for (genvar g = 1; g <= RD_DQM_LAT; g++) begin : gDqmPipe
    always_ff @(posedge clk) begin
      if (!rstN) dqmPipe[g] <= '0;
      else if (g == 1) dqmPipe[g] <= dqmIn;
      else dqmPipe[g] <= dqmPipe[g-1];
    end
  end

  assign rdValid  = casIs3 ? rdPipe[CAS_HI] : rdPipe[CAS_LO];
  assign rdLaneOe = {MASK_W{rdValid}} & ~dqmPipe[RD_DQM_LAT];
  assign wrLaneEn = {MASK_W{strb.wrFire}} & ~dqmIn;

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.load) |=> (idxQ == $past(idxQ) + COL_W'(1)));   // R2
  AST_RD_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ($past(strb.rdFire, 2) || $past(strb.rdFire, 3)));          // R7
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int MASK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startRd,
  input  logic              startWr,
  input  logic [COL_W-1:0]  startCol,
  input  logic [2:0]        lenCode,
  input  logic              interleave,
  input  logic              casIs3,
  input  logic              burstStop,
  input  logic [MASK_W-1:0] dqmIn,
  output logic              beatValid,
  output logic [COL_W-1:0]  beatIdx,
  output logic [COL_W-1:0]  beatCol,
  output logic              lastBeat,
  output logic              rdValid,
  output logic [MASK_W-1:0] rdLaneOe,
  output logic [MASK_W-1:0] wrLaneEn
);
  seqStrobe_t       strb;
  logic [COL_W-1:0] lenMask;
  logic             ilQ;

  bcs_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startRd(startRd), .startWr(startWr),
    .lenCode(lenCode), .interleave(interleave), .burstStop(burstStop),
    .beatIdx(beatIdx), .strb(strb), .lenMaskQ(lenMask), .ilQ(ilQ),
    .beatValid(beatValid), .lastBeat(lastBeat)
  );

  bcs_dpath #(.COL_W(COL_W), .MASK_W(MASK_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .startCol(startCol),
    .lenMask(lenMask), .il(ilQ), .casIs3(casIs3), .dqmIn(dqmIn),
    .beatIdx(beatIdx), .beatCol(beatCol), .rdValid(rdValid),
    .rdLaneOe(rdLaneOe), .wrLaneEn(wrLaneEn)
  );
endmodule

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
  localparam int COL_W  = 9;
  localparam int MASK_W = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startRd = 1'b0, startWr = 1'b0;
  logic [COL_W-1:0]  startCol = '0;
  logic [2:0]        lenCode = '0;
  logic              interleave = 1'b0, casIs3 = 1'b0, burstStop = 1'b0;
  logic [MASK_W-1:0] dqmIn = '0;
  logic              beatValid, lastBeat, rdValid;
  logic [COL_W-1:0]  beatIdx, beatCol;
  logic [MASK_W-1:0] rdLaneOe, wrLaneEn;

  int nChecks = 0;
  int nFail   = 0;
  int cyc     = 0;
  bit                rdBeatAt [0:65535];
  logic [MASK_W-1:0] dqmAt    [0:65535];

  burst_col_seq #(.COL_W(COL_W), .MASK_W(MASK_W)) u_burst_col_seq (
    .clk(clk), .rstN(rstN), .startRd(startRd), .startWr(startWr),
    .startCol(startCol), .lenCode(lenCode), .interleave(interleave),
    .casIs3(casIs3), .burstStop(burstStop), .dqmIn(dqmIn),
    .beatValid(beatValid), .beatIdx(beatIdx), .beatCol(beatCol),
    .lastBeat(lastBeat), .rdValid(rdValid), .rdLaneOe(rdLaneOe),
    .wrLaneEn(wrLaneEn)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int lenOf(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 512;
      default: return 1;
    endcase
  endfunction

  // read-side monitor: R7 latency and R9 mask latency
  always @(negedge clk) begin
    int expRd;
    int expOe;
    #2;
    dqmAt[cyc] = dqmIn;
    if (rstN && cyc >= 4) begin
      expRd = casIs3 ? int'(rdBeatAt[cyc-3]) : int'(rdBeatAt[cyc-2]);
      chk("R7 rdValid", int'(rdValid), expRd);
      expOe = expRd != 0 ? int'(~dqmAt[cyc-2]) & 3 : 0;
      chk("R9 rdLaneOe", int'(rdLaneOe), expOe);
    end
  end

  task automatic runBurst(input bit rd, input int code, input bit il,
                          input int col, input int stopAt, input int nBeats);
    int L;
    int base;
    int expCol;
    int expWr;
    logic [1:0] d;
    string colTag;
    L = lenOf(code);
    base = col - (col % L);
    if (code == 7) colTag = "R5 beatCol";
    else if (code >= 4) colTag = "R10 beatCol";
    else if (il) colTag = "R4 beatCol";
    else colTag = "R3 beatCol";
    @(negedge clk);
    startRd = rd; startWr = !rd; lenCode = code[2:0]; interleave = il;
    startCol = col[COL_W-1:0]; burstStop = 1'b0; dqmIn = '0;
    for (int k = 0; k < nBeats; k++) begin
      @(negedge clk);
      startRd = 1'b0; startWr = 1'b0;
      burstStop = (k == stopAt);
      d = 2'((k + col) % 4);
      dqmIn = d;
      if (rd && k != stopAt) rdBeatAt[cyc] = 1'b1;
      #1;
      if (il && code != 7 && L > 1) expCol = base + ((col % L) ^ (k % L));
      else expCol = base + ((col + k) % L);
      chk(colTag, int'(beatCol), expCol);
      chk("R2 beatValid", int'(beatValid), 1);
      chk("R2 beatIdx", int'(beatIdx), k % L);
      chk(code == 7 ? "R5 lastBeat" : "R2 lastBeat", int'(lastBeat),
          (code != 7 && k == L - 1) ? 1 : 0);
      expWr = (rd || k == stopAt) ? 0 : (int'(~d) & 3);
      chk(k == stopAt ? "R6 wrLaneEn" : "R8 wrLaneEn", int'(wrLaneEn), expWr);
    end
    @(negedge clk);
    burstStop = 1'b0; dqmIn = '0;
    #1;
    chk(stopAt >= 0 ? "R6 beatValid end" : "R2 beatValid end", int'(beatValid), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R1 beatValid", int'(beatValid), 0);
    chk("R1 rdValid", int'(rdValid), 0);
    chk("R1 lanes", int'({rdLaneOe, wrLaneEn}), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 lastBeat", int'(lastBeat), 0);
    chk("R1 beatValid after release", int'(beatValid), 0);

    // sweep: codes 0..6, both orders, 16 start offsets, read and write
    for (int code = 0; code < 7; code++)
      for (int il = 0; il < 2; il++)
        for (int col = 0; col < 16; col++)
          for (int rd = 0; rd < 2; rd++) begin
            casIs3 = col[0];
            runBurst(rd[0], code, il[0], col + 32 * code, -1, lenOf(code));
          end

    // R5: page burst across column 511, interleave requested but ignored
    casIs3 = 1'b1;
    runBurst(1'b0, 7, 1'b1, 500, 519, 520);
    runBurst(1'b1, 7, 1'b0, 508, 9, 10);

    // R6: stops cutting reads and writes short
    casIs3 = 1'b0;
    runBurst(1'b1, 3, 1'b0, 13, 3, 4);
    runBurst(1'b0, 3, 1'b1, 21, 2, 3);
    runBurst(1'b0, 2, 1'b0, 6, 0, 1);

    // R11: restart in the middle of a read burst with a write burst
    @(negedge clk);
    startRd = 1'b1; startWr = 1'b0; lenCode = 3'd3; interleave = 1'b0;
    startCol = 9'd5;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      startRd = 1'b0;
      if (k == 2) begin
        startWr = 1'b1; startCol = 9'd9; lenCode = 3'd2;
      end
      rdBeatAt[cyc] = 1'b1;
      #1;
      chk("R11 old beatCol", int'(beatCol), 5 + k);
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      startWr = 1'b0;
      #1;
      chk("R11 new beatIdx", int'(beatIdx), k);
      chk("R11 new beatCol", int'(beatCol), 8 + ((1 + k) % 4));
      chk("R11 new wrLaneEn", int'(wrLaneEn), 3);
      chk("R11 new lastBeat", int'(lastBeat), k == 3 ? 1 : 0);
    end
    repeat (4) @(negedge clk);

    // R11: simultaneous read and write start, read wins
    startRd = 1'b1; startWr = 1'b1; lenCode = 3'd1; startCol = 9'd3;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      startRd = 1'b0; startWr = 1'b0;
      rdBeatAt[cyc] = 1'b1;
      #1;
      chk("R11 both-start wrLaneEn", int'(wrLaneEn), 0);
      chk("R11 both-start beatCol", int'(beatCol), 2 + ((1 + k) % 2));
    end
    repeat (6) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    nFail++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule